// File: doc/BRIEF.md
# Filtered Message Capture Memory

This block keeps a record of reply messages arriving from the readout channels. Each reply carries these fields:

- a 4-bit request tag
- a 24-bit orbit number
- a 12-bit bunch-crossing number
- an 8-bit source identifier
- an 8-bit channel number

The block first tests the channel number against a programmable pattern. Each pattern bit has its own compare enable. A reply that passes the filter is written as four 16-bit words into a word-addressed memory of `DEPTH` entries, which is 4096 by default.

A write pointer marks where the next record will start. It moves forward by four words for every stored reply and wraps around the memory. The host reads and writes the memory through a simple request/acknowledge port. Capture owns the single memory port while it is writing a record. A host request that arrives during that time waits until the four writes are done.

Top module: `filtered_capture_mem`

## Requirements
- R1: The first word of a stored record sits at the record's base address, which has low address bits 00. It holds {4'h0, request tag[3:0], orbit[23:16]}.
- R2: The second word, at base+1 (low bits 01), holds orbit[15:0].
- R3: The third word, at base+2 (low bits 10), holds {4'h0, bunch[11:0]}.
- R4: The fourth word, at base+3 (low bits 11), holds {source[7:0], channel[7:0]}. Source is in bits 15:8.
- R5: `wr_ptr` is 0 after reset. It shows the base address of the next record. It increases by 4 for each stored reply and reaches its new value in the cycle in which `capture_busy` falls.
- R6: The pointer wraps modulo `DEPTH`. The record after the one at `DEPTH-4` starts at address 0 and overwrites it.
- R7: `filter_cfg[7:0]` is the pattern and `filter_cfg[15:8]` holds the per-bit enables. A reply is stored exactly when ((channel XOR pattern) AND enables) == 0, so 16'h0000 stores every reply.
- R8: A reply that fails the filter changes neither `wr_ptr` nor any memory word, and does not raise `capture_busy`.
- R9: A reply sampled while `capture_busy` is low and passing the filter raises `capture_busy` for exactly four cycles, beginning the next cycle. `msg_valid` is ignored while `capture_busy` is high.
- R10: A host request (`host_req` held high with `host_we`, `host_addr`, `host_wdata`) is served with a one-cycle `host_ack` pulse. For a read, `host_rdata` is valid while `host_ack` is high. A written word reads back unchanged.
- R11: A host request pending while `capture_busy` is high gets no `host_ack` until the record is complete. A held write to a record address then lands after the capture writes, so the host value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | A reply is present on the msg_* inputs this cycle |
| msg_req_id | input | 4 | Request tag of the reply |
| msg_orbit | input | 24 | Orbit number of the reply |
| msg_bunch | input | 12 | Bunch-crossing number of the reply |
| msg_src | input | 8 | Source identifier of the reply |
| msg_chan | input | 8 | Channel number of the reply |
| filter_cfg | input | 16 | Bits 15:8 are the compare enables, bits 7:0 the pattern |
| host_req | input | 1 | Host access request, held until acknowledged |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Host word address |
| host_wdata | input | 16 | Host write data |
| host_ack | output | 1 | One-cycle pulse when the host access is performed |
| host_rdata | output | 16 | Read data, valid while host_ack is high |
| capture_busy | output | 1 | A record is being written |
| wr_ptr | output | PTR_W | Base address of the next record |

## Verification
A wrong pointer shows up at `wr_ptr` in the cycle `capture_busy` falls. It also shows up later, when records land at the wrong words during the full-memory readback that follows each sweep. A wrong filter decision shows as an extra or missing four-cycle busy pulse in the cycle right after the reply is offered. A broken word layout appears only when the memory is read back, one word off per faulty field. An arbitration fault shows as an early `host_ack` during a busy window, or as a capture word left where the host value should be.

// File: rtl/fcm_pkg.sv
package fcm_pkg;

  localparam int WORD_W = 16;
  localparam int CHAN_W = 8;

  typedef struct packed {
    logic [3:0]  req_id;
    logic [23:0] orbit;
    logic [11:0] bunch;
    logic [7:0]  src;
    logic [7:0]  chan;
  } reply_t;

  typedef enum logic [2:0] {
    CAP_IDLE,
    CAP_W0,
    CAP_W1,
    CAP_W2,
    CAP_W3
  } cap_state_e;

  // Format one of the four record words; sel is the low address bits.
  function automatic logic [WORD_W-1:0] reply_word(input reply_t m, input logic [1:0] sel);
    logic [WORD_W-1:0] w;
    case (sel)
      2'd0:    w = {4'h0, m.req_id, m.orbit[23:16]};
      2'd1:    w = m.orbit[15:0];
      2'd2:    w = {4'h0, m.bunch};
      default: w = {m.src, m.chan};
    endcase
    return w;
  endfunction

endpackage

// File: rtl/fcm_chan_filter.sv
module fcm_chan_filter #(
  parameter int CH_W = 8
) (
  input  logic [CH_W-1:0]   chan,
  input  logic [2*CH_W-1:0] cfg,
  output logic              pass
);

  logic [CH_W-1:0] bit_ok;

  // Each bit either has its compare disabled or equals the pattern bit.
  for (genvar i = 0; i < CH_W; i++) begin : g_bit
    assign bit_ok[i] = !cfg[CH_W+i] || (chan[i] == cfg[i]);
  end

  assign pass = &bit_ok;

endmodule

// File: rtl/fcm_capture_seq.sv
module fcm_capture_seq
  import fcm_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PTR_W  = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              msg_valid,
  input  reply_t            msg,
  input  logic              pass,
  output logic              busy,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data
);

  cap_state_e        state;
  logic [ADDR_W-1:0] base;
  reply_t            held;
  logic [1:0]        sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= CAP_IDLE;
      base  <= '0;
      held  <= '0;
    end else begin
      case (state)
        CAP_IDLE: if (msg_valid && pass) begin
          held  <= msg;
          state <= CAP_W0;
        end
        CAP_W0:  state <= CAP_W1;
        CAP_W1:  state <= CAP_W2;
        CAP_W2:  state <= CAP_W3;
        CAP_W3: begin
          state <= CAP_IDLE;
          base  <= base + ADDR_W'(4);
        end
        default: state <= CAP_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state)
      CAP_W1:  sel = 2'd1;
      CAP_W2:  sel = 2'd2;
      CAP_W3:  sel = 2'd3;
      default: sel = 2'd0;
    endcase
  end

  assign busy    = (state != CAP_IDLE);
  assign wr_en   = busy;
  assign wr_addr = {base[ADDR_W-1:2], sel};
  assign wr_data = reply_word(held, sel);
  assign ptr_o   = {{(PTR_W-ADDR_W){1'b0}}, base};

  // R5 / R6: the pointer only ever moves by one record, modulo the depth.
  p_ptr_step_r6: assert property (@(posedge clk) disable iff (rst)
    (ptr_o != $past(ptr_o)) |-> (ptr_o[ADDR_W-1:0] == $past(ptr_o[ADDR_W-1:0]) + ADDR_W'(4)));

  // R5: pointer moves exactly when the busy window closes.
  p_ptr_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (ptr_o != $past(ptr_o)));

  // R9: a capture lasts exactly four cycles.
  p_busy_four_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> busy ##1 busy ##1 busy ##1 busy ##1 !busy);

  // R8: a rejected reply starts nothing and leaves the pointer alone.
  p_reject_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && msg_valid && !pass) |=> (!busy && $stable(ptr_o)));

endmodule

// File: rtl/fcm_ram.sv
module fcm_ram #(
  parameter int DEPTH = 4096,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata     <= mem[addr];
  end

endmodule

// File: rtl/filtered_capture_mem.sv
module filtered_capture_mem
  import fcm_pkg::*;
#(
  parameter int DEPTH   = 4096,
  parameter int PTR_W   = 14,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              msg_valid,
  input  logic [3:0]        msg_req_id,
  input  logic [23:0]       msg_orbit,
  input  logic [11:0]       msg_bunch,
  input  logic [7:0]        msg_src,
  input  logic [7:0]        msg_chan,
  input  logic [15:0]       filter_cfg,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [15:0]       host_wdata,
  output logic              host_ack,
  output logic [15:0]       host_rdata,
  output logic              capture_busy,
  output logic [PTR_W-1:0]  wr_ptr
);

  reply_t            msg;
  logic              pass;
  logic              cap_we;
  logic [ADDR_W-1:0] cap_addr;
  logic [WORD_W-1:0] cap_data;
  logic              host_go;
  logic              ack_q;
  logic              ram_we;
  logic              ram_re;
  logic [ADDR_W-1:0] ram_addr;
  logic [WORD_W-1:0] ram_wdata;

  assign msg = '{req_id: msg_req_id, orbit: msg_orbit, bunch: msg_bunch,
                 src: msg_src, chan: msg_chan};

  fcm_chan_filter #(.CH_W(CHAN_W)) u_filter (
    .chan (msg_chan),
    .cfg  (filter_cfg),
    .pass (pass)
  );

  fcm_capture_seq #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .msg_valid (msg_valid),
    .msg       (msg),
    .pass      (pass),
    .busy      (capture_busy),
    .ptr_o     (wr_ptr),
    .wr_en     (cap_we),
    .wr_addr   (cap_addr),
    .wr_data   (cap_data)
  );

  // Capture owns the port while busy; host gets it otherwise.
  assign host_go   = host_req && !cap_we && !ack_q;
  assign ram_we    = cap_we || (host_go && host_we);
  assign ram_re    = host_go && !host_we;
  assign ram_addr  = cap_we ? cap_addr : host_addr;
  assign ram_wdata = cap_we ? cap_data : host_wdata;

  always_ff @(posedge clk) begin
    if (rst) ack_q <= 1'b0;
    else     ack_q <= host_go;
  end

  assign host_ack = ack_q;

  fcm_ram #(.DEPTH(DEPTH), .W(WORD_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .re    (ram_re),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (host_rdata)
  );

  // R11: no host access completes in the cycle after a capture cycle.
  p_hold_off_r11: assert property (@(posedge clk) disable iff (rst)
    capture_busy |=> !host_ack);

  // R10: acknowledge is a single-cycle pulse.
  p_ack_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    host_ack |=> !host_ack);

  // R10: an acknowledge always answers a pending request.
  p_ack_has_req_r10: assert property (@(posedge clk) disable iff (rst)
    host_ack |-> $past(host_req));

endmodule

// File: tb/filtered_capture_mem_test.sv
module filtered_capture_mem_test;

  localparam int DEPTH = 64;
  localparam int PTR_W = 14;
  localparam int AW    = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic msg_valid = 1'b0;
  logic [3:0] msg_req_id = '0;
  logic [23:0] msg_orbit = '0;
  logic [11:0] msg_bunch = '0;
  logic [7:0] msg_src = '0;
  logic [7:0] msg_chan = '0;
  logic [15:0] filter_cfg = '0;
  logic host_req = 1'b0;
  logic host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic host_ack;
  logic [15:0] host_rdata;
  logic capture_busy;
  logic [PTR_W-1:0] wr_ptr;

  int nchk = 0;
  int nerr = 0;
  int eptr = 0;
  logic [15:0] expm [DEPTH];

  always #2.5 clk = ~clk;

  filtered_capture_mem #(.DEPTH(DEPTH), .PTR_W(PTR_W)) uut (
    .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_req_id(msg_req_id),
    .msg_orbit(msg_orbit), .msg_bunch(msg_bunch), .msg_src(msg_src),
    .msg_chan(msg_chan), .filter_cfg(filter_cfg), .host_req(host_req),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_ack(host_ack), .host_rdata(host_rdata),
    .capture_busy(capture_busy), .wr_ptr(wr_ptr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit passes(input logic [7:0] ch, input logic [15:0] cfg);
    return ((ch ^ cfg[7:0]) & cfg[15:8]) == 8'h00;
  endfunction

  task automatic host_write(input int a, input logic [15:0] d);
    host_req = 1'b1; host_we = 1'b1; host_addr = AW'(a); host_wdata = d;
    do @(negedge clk); while (!host_ack);
    host_req = 1'b0; host_we = 1'b0;
  endtask

  task automatic host_read(input int a, output logic [15:0] d);
    host_req = 1'b1; host_we = 1'b0; host_addr = AW'(a);
    do @(negedge clk); while (!host_ack);
    d = host_rdata;
    host_req = 1'b0;
  endtask

  task automatic model_store(input logic [3:0] rq, input logic [23:0] orb,
                             input logic [11:0] bun, input logic [7:0] src,
                             input logic [7:0] ch);
    expm[eptr]   = {4'h0, rq, orb[23:16]};
    expm[eptr+1] = orb[15:0];
    expm[eptr+2] = {4'h0, bun};
    expm[eptr+3] = {src, ch};
  endtask

  // Offer one reply for one cycle and follow the busy window.
  task automatic send_msg(input logic [3:0] rq, input logic [23:0] orb,
                          input logic [11:0] bun, input logic [7:0] src,
                          input logic [7:0] ch);
    bit ok;
    ok = passes(ch, filter_cfg);
    msg_valid = 1'b1; msg_req_id = rq; msg_orbit = orb;
    msg_bunch = bun; msg_src = src; msg_chan = ch;
    @(negedge clk);
    msg_valid = 1'b0;
    if (ok) begin
      model_store(rq, orb, bun, src, ch);
      for (int k = 0; k < 4; k++) begin
        chk("R9 busy window", 32'(capture_busy), 32'd1);
        @(negedge clk);
      end
      chk("R9 busy ends", 32'(capture_busy), 32'd0);
      eptr = (eptr + 4) % DEPTH;
      chk("R5/R6 pointer after store", 32'(wr_ptr), 32'(eptr));
    end else begin
      chk("R8 reject no busy", 32'(capture_busy), 32'd0);
      chk("R8 reject pointer", 32'(wr_ptr), 32'(eptr));
    end
  endtask

  task automatic readback(input string tag);
    logic [15:0] d;
    for (int a = 0; a < DEPTH; a++) begin
      host_read(a, d);
      case (a % 4)
        0: chk({tag, " R1 word0"}, 32'(d), 32'(expm[a]));
        1: chk({tag, " R2 word1"}, 32'(d), 32'(expm[a]));
        2: chk({tag, " R3 word2"}, 32'(d), 32'(expm[a]));
        default: chk({tag, " R4 word3"}, 32'(d), 32'(expm[a]));
      endcase
    end
  endtask

  initial begin
    #(5.0 * 150000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int base;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R5 reset pointer", 32'(wr_ptr), 32'd0);
    chk("R9 reset busy", 32'(capture_busy), 32'd0);
    chk("R10 reset ack", 32'(host_ack), 32'd0);

    // R10: host fill and readback.
    for (int a = 0; a < DEPTH; a++) begin
      expm[a] = 16'((a * 16'h0357) ^ 16'hA5C3);
      host_write(a, expm[a]);
    end
    readback("R10 host fill");

    // Accept all; 20 records wrap the 16-record memory (R6).
    filter_cfg = 16'h0000;
    for (int i = 0; i < 20; i++)
      send_msg(4'(i * 3 + 1), 24'(i * 24'h01F3A7 + 24'h8000), 12'(i * 12'h1B7),
               8'(8'hC0 + i), 8'(i * 29));
    readback("R6 wrap");

    // R7: enables on high nibble, pattern A; all 256 channels.
    filter_cfg = 16'hF0A0;
    for (int c = 0; c < 256; c++)
      send_msg(4'(c), {8'(c), 8'(~c), 8'(c * 7)}, 12'(c * 13), 8'(255 - c), 8'(c));
    readback("R7 nibble filter");

    // R7/R8: every enable set, single channel passes.
    filter_cfg = 16'hFF5A;
    for (int c = 0; c < 256; c++)
      send_msg(4'(~c), {8'(c * 5), 16'(c * 16'h0101)}, 12'(c), 8'(c ^ 8'h3C), 8'(c));
    readback("R8 exact filter");

    // R7: two low bits enabled, pattern 01.
    filter_cfg = 16'h0301;
    for (int c = 0; c < 64; c++)
      send_msg(4'(c), 24'(c * 1000), 12'(c * 61), 8'(c), 8'(c));

    // R9: a second valid during busy is ignored.
    filter_cfg = 16'h0000;
    msg_valid = 1'b1; msg_req_id = 4'h9; msg_orbit = 24'h123456;
    msg_bunch = 12'hABC; msg_src = 8'h77; msg_chan = 8'h42;
    model_store(4'h9, 24'h123456, 12'hABC, 8'h77, 8'h42);
    @(negedge clk);
    msg_chan = 8'h43; msg_src = 8'h11;
    @(negedge clk);
    msg_valid = 1'b0;
    repeat (3) @(negedge clk);
    eptr = (eptr + 4) % DEPTH;
    chk("R9 ignored valid pointer", 32'(wr_ptr), 32'(eptr));
    chk("R9 ignored valid busy", 32'(capture_busy), 32'd0);

    // R11: host write queued behind a capture.
    base = eptr;
    msg_valid = 1'b1; msg_req_id = 4'h5; msg_orbit = 24'hFEDCBA;
    msg_bunch = 12'h321; msg_src = 8'h0F; msg_chan = 8'hF0;
    model_store(4'h5, 24'hFEDCBA, 12'h321, 8'h0F, 8'hF0);
    @(negedge clk);
    msg_valid = 1'b0;
    host_req = 1'b1; host_we = 1'b1; host_addr = AW'(base + 1); host_wdata = 16'hBEEF;
    for (int n = 1; n <= 5; n++) begin
      @(negedge clk);
      chk("R11 ack held off", 32'(host_ack), 32'(n == 5));
    end
    host_req = 1'b0; host_we = 1'b0;
    expm[base+1] = 16'hBEEF;
    eptr = (eptr + 4) % DEPTH;
    chk("R11 pointer", 32'(wr_ptr), 32'(eptr));
    readback("R11 final");

    host_read(base + 1, d);
    chk("R11 host value wins", 32'(d), 32'h0000BEEF);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule